// File: doc/BRIEF.md
# Audio controller interrupt combiner

This block gathers every interrupt source of a multi-stream audio controller into one 32-bit interrupt status word and a single level-sensitive interrupt line. The sources are the response-ring status and control bits, the codec state-change flags with their wake enables, a three-bit status field and a three-bit control field for each stream, and the global interrupt control word. The source status bits arrive as plain inputs. Clearing them, decoding the register bus and signalling on the host bus are handled elsewhere.

The status word is rebuilt from the inputs on every clock and latched into a register that can be read back. The interrupt line is latched on the same edge. The status word does not depend on the enables in the interrupt control word. The line does depend on them. For this reason the global status bit can read as set while the line stays low.

Top module: `audio_irq_combiner`

## Requirements
- R1: Status bit 30 (controller) is set when `ring_status & ring_ctrl` is nonzero. Bit 0 of each ring input is response-interrupt and bit 1 is overrun.
- R2: Status bit 30 is also set when any `codec_change` bit is set and the same bit of `codec_wake_en` is set.
- R3: Status bit n is set for stream n when its three-bit status field ANDed with its three-bit control field is nonzero. Stream n owns bits [3n+2:3n]: bit 3n is completion, 3n+1 is FIFO error, and 3n+2 is descriptor error.
- R4: Status bit 31 (global) is set exactly when any other status bit is set.
- R5: The interrupt line goes high when `irq_ctrl[31]` (global enable) is set and the status ANDed with `irq_ctrl` is nonzero in bit 30 or in bits NSTREAM-1:0.
- R6: The interrupt line is low whenever the R5 condition fails. This includes the case where status bit 31 is set and every source enable is clear.
- R7: Status bits NSTREAM..29 always read 0, and `irq_ctrl` bits NSTREAM..29 have no effect on the line.
- R8: Both outputs are registered: they reflect the inputs sampled at the previous rising edge. While `rst_n` is low, both outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_status | input | 2 | Response-ring status: bit 0 response, bit 1 overrun |
| ring_ctrl | input | 2 | Response-ring interrupt enables, same bit layout |
| codec_change | input | NCODEC | Codec state-change flags |
| codec_wake_en | input | NCODEC | Per-codec wake enables |
| stream_status | input | 3*NSTREAM | Per-stream status fields |
| stream_ctrl | input | 3*NSTREAM | Per-stream interrupt enable fields |
| irq_ctrl | input | 32 | Global enable (31), controller enable (30), stream enables (NSTREAM-1:0) |
| irq_status | output | 32 | Latched interrupt status word |
| irq | output | 1 | Latched interrupt line level |

## Verification
Each output is a single register stage away from the inputs. A wrong next-state term therefore shows on `irq_status` or `irq` at the first rising edge after the stimulus that exposes it. The bench compares at every edge, so an error is caught in the same cycle it appears. A wrongly combined enable shows as a line that disagrees with the status word it was latched with. The gated case, where the global bit is set but the line is low, is the one most likely to be wrong, and the bench drives it directly.

// File: rtl/audio_irq_combiner.sv
module audio_irq_combiner #(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             ring_status,
  input  logic [1:0]             ring_ctrl,
  input  logic [NCODEC-1:0]      codec_change,
  input  logic [NCODEC-1:0]      codec_wake_en,
  input  logic [3*NSTREAM-1:0]   stream_status,
  input  logic [3*NSTREAM-1:0]   stream_ctrl,
  input  logic [31:0]            irq_ctrl,
  output logic [31:0]            irq_status,
  output logic                   irq
);
  localparam int          CTRL_BIT    = 30;
  localparam int          GLOBAL_BIT  = 31;
  localparam logic [31:0] STREAM_MASK = 32'((64'd1 << NSTREAM) - 64'd1);
  localparam logic [31:0] ENABLE_MASK = STREAM_MASK | (32'd1 << CTRL_BIT);

  logic [NSTREAM-1:0] stream_hit;
  logic               ctrl_hit;
  logic [31:0]        next_status;
  logic               next_irq;

  for (genvar n = 0; n < NSTREAM; n++) begin : g_stream
    assign stream_hit[n] = |(stream_status[3*n +: 3] & stream_ctrl[3*n +: 3]);
  end

  assign ctrl_hit = (|(ring_status & ring_ctrl)) | (|(codec_change & codec_wake_en));

  always_comb begin
    next_status                 = '0;
    next_status[NSTREAM-1:0]    = stream_hit;
    next_status[CTRL_BIT]       = ctrl_hit;
    next_status[GLOBAL_BIT]     = ctrl_hit | (|stream_hit);
  end

  assign next_irq = irq_ctrl[GLOBAL_BIT] && |(next_status & irq_ctrl & ENABLE_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_status <= '0;
      irq        <= 1'b0;
    end else begin
      irq_status <= next_status;
      irq        <= next_irq;
    end
  end
endmodule

// File: rtl/irq_combiner_props.sv
module irq_combiner_props #(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           ring_status,
  input logic [1:0]           ring_ctrl,
  input logic [NCODEC-1:0]    codec_change,
  input logic [NCODEC-1:0]    codec_wake_en,
  input logic [3*NSTREAM-1:0] stream_status,
  input logic [3*NSTREAM-1:0] stream_ctrl,
  input logic [31:0]          irq_ctrl,
  input logic [31:0]          irq_status,
  input logic                 irq
);
  localparam logic [31:0] KEEP_MASK = 32'((64'd1 << NSTREAM) - 64'd1) | 32'hC000_0000;

  p_ring_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(|(ring_status & ring_ctrl)) |-> irq_status[30]);

  p_codec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(|(codec_change & codec_wake_en)) |-> irq_status[30]);

  p_stream_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(|(stream_status & stream_ctrl)) |-> irq_status[31]);

  p_global_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[31] == (|irq_status[30:0]));

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_ctrl[31]));

  p_irq_needs_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_status[31]);

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status & ~KEEP_MASK) == 32'd0);

  p_reset_r8: assert property (@(posedge clk)
    !rst_n |=> (irq == 1'b0) && (irq_status == 32'd0));
endmodule

bind audio_irq_combiner irq_combiner_props #(.NSTREAM(NSTREAM), .NCODEC(NCODEC)) u_props (.*);

// File: tb/audio_irq_combiner_test.sv
module audio_irq_combiner_test;
  localparam int NS = 2;
  localparam int NC = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic [1:0]      ring_status, ring_ctrl;
  logic [NC-1:0]   codec_change, codec_wake_en;
  logic [3*NS-1:0] stream_status, stream_ctrl;
  logic [31:0]     irq_ctrl;
  logic [31:0]     irq_status;
  logic            irq;

  audio_irq_combiner #(.NSTREAM(NS), .NCODEC(NC)) uut (
    .clk(clk), .rst_n(rst_n),
    .ring_status(ring_status), .ring_ctrl(ring_ctrl),
    .codec_change(codec_change), .codec_wake_en(codec_wake_en),
    .stream_status(stream_status), .stream_ctrl(stream_ctrl),
    .irq_ctrl(irq_ctrl), .irq_status(irq_status), .irq(irq));

  int tests = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_status(input logic [1:0] rs, input logic [1:0] rc,
      input logic [NC-1:0] cc, input logic [NC-1:0] cw,
      input logic [3*NS-1:0] ss, input logic [3*NS-1:0] sc);
    logic [31:0] s = '0;
    for (int n = 0; n < NS; n++)
      if (((ss >> (3*n)) & (sc >> (3*n)) & 6'd7) != 0) s[n] = 1'b1;
    if ((rs & rc) != 0 || (cc & cw) != 0) s[30] = 1'b1;
    if (s != 0) s[31] = 1'b1;
    return s;
  endfunction

  function automatic logic model_irq(input logic [31:0] s, input logic [31:0] c);
    return c[31] && ((s & c & (32'h4000_0000 | ((32'd1 << NS) - 32'd1))) != 0);
  endfunction

  task automatic drive(input logic [1:0] rs, input logic [1:0] rc, input logic [NC-1:0] cc,
      input logic [NC-1:0] cw, input logic [3*NS-1:0] ss, input logic [3*NS-1:0] sc,
      input logic [31:0] ic);
    @(negedge clk);
    ring_status = rs; ring_ctrl = rc; codec_change = cc; codec_wake_en = cw;
    stream_status = ss; stream_ctrl = sc; irq_ctrl = ic;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] es;
    rst_n = 1'b0;
    drive(2'b11, 2'b11, '1, '1, '1, '1, 32'hFFFF_FFFF);
    check(irq_status == 32'd0, "R8 reset status", irq_status, 0);
    check(irq == 1'b0, "R8 reset irq", 32'(irq), 0);
    rst_n = 1'b1;

    drive(2'b10, 2'b10, '0, '0, '0, '0, 32'hC000_0000);
    check(irq_status == 32'hC000_0000, "R1 overrun status", irq_status, 32'hC000_0000);
    check(irq == 1'b1, "R1 irq", 32'(irq), 1);
    drive(2'b01, 2'b10, '0, '0, '0, '0, 32'hC000_0000);
    check(irq_status == 32'd0, "R1 no overlap", irq_status, 0);
    check(irq == 1'b0, "R6 no source", 32'(irq), 0);

    drive(2'b00, 2'b00, 3'b100, 3'b100, '0, '0, 32'hC000_0000);
    check(irq_status == 32'hC000_0000, "R2 codec wake", irq_status, 32'hC000_0000);
    drive(2'b00, 2'b00, 3'b011, 3'b100, '0, '0, 32'hC000_0000);
    check(irq_status == 32'd0, "R2 masked codec", irq_status, 0);

    drive(2'b00, 2'b00, '0, '0, 6'b100000, 6'b100000, 32'h8000_0002);
    check(irq_status == 32'h8000_0002, "R3 stream1 descriptor", irq_status, 32'h8000_0002);
    check(irq == 1'b1, "R5 stream1 irq", 32'(irq), 1);
    drive(2'b00, 2'b00, '0, '0, 6'b000010, 6'b000010, 32'h8000_0001);
    check(irq_status == 32'h8000_0001, "R3 stream0 fifo", irq_status, 32'h8000_0001);

    drive(2'b00, 2'b00, '0, '0, 6'b100000, 6'b100000, 32'h4000_0003);
    check(irq == 1'b0, "R6 global enable off", 32'(irq), 0);
    check(irq_status == 32'h8000_0002, "R4 status ungated", irq_status, 32'h8000_0002);
    drive(2'b00, 2'b00, '0, '0, 6'b100000, 6'b100000, 32'h8000_0000);
    check(irq == 1'b0 && irq_status[31], "R6 global bit alone", {irq_status[31:1], irq}, 32'h8000_0000);

    drive(2'b00, 2'b00, '0, '0, 6'b100000, 6'b100000, 32'h8000_0004);
    check(irq == 1'b0, "R7 unused enable bit", 32'(irq), 0);

    @(negedge clk);
    stream_ctrl = '0;
    #1;
    check(irq == 1'b0, "R8 output before edge", 32'(irq), 0);
    irq_ctrl = 32'h8000_0002; stream_ctrl = 6'b100000;
    #1;
    check(irq == 1'b0, "R8 no combinational path", 32'(irq), 0);
    @(posedge clk); #1;
    check(irq == 1'b1, "R8 after edge", 32'(irq), 1);

    for (int i = 0; i < 30000; i++) begin
      logic [31:0] a, b, c;
      a = $urandom; b = $urandom; c = $urandom;
      drive(a[1:0], a[3:2], a[6:4], a[9:7], b[5:0], b[11:6], c);
      es = model_status(a[1:0], a[3:2], a[6:4], a[9:7], b[5:0], b[11:6]);
      check(irq_status == es, "R1/R2/R3/R4/R7 sweep status", irq_status, es);
      check(irq == model_irq(es, c), "R5/R6 sweep irq", 32'(irq), 32'(model_irq(es, c)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule